// File: doc/BRIEF.md
# Conversion Sequence Program Memory

This block holds a short program of conversion set-ups for a multiplexed converter. Each step of the program is a six-bit configuration word: a differential-pair select, a three-bit channel address, a bipolar-range select and a gain select. A two-bit mode input picks what the block does. In access mode, software loads the program one word per write strobe and can read it back one word per read strobe. In run mode, every conversion-start pulse hands the next word to the converter. At the end of the program the block returns to the first word.

A single pointer serves loading, readback and playback. Any change on either mode bit returns that pointer to entry 0, so every phase starts from the top of the program. The highest entry written in the most recent loading session is the last step of the program. That entry is reported with an end-of-program flag, both on readback and on playback. The stored words stay in place when the mode changes.

All inputs are synchronous to `clk`. The three strobes are active low. The block acts on a strobe edge one clock after it samples that edge.

Top module: `seq_program_mem`

## Requirements
- R1: After reset, `stat_oe` and `conv_vld` are 0, the pointer is 0, all 16 entries hold 0, and entry 15 is the end of the program.
- R2: In access mode (`mode`=2'b10) with `rd_n` high, a rising edge of `wr_n` stores `cfg_in` at the pointer and then advances the pointer. The `cfg_in` bits are [5] differential, [4:2] channel address, [1] bipolar, [0] gain.
- R3: In access mode with `wr_n` high, a falling edge of `rd_n` sets `stat_oe` and drives `stat_out` = {entry[5:0], end flag}. The end flag is bit 0. The following rising edge of `rd_n` clears `stat_oe` and advances the pointer.
- R4: Readback walks all 16 entries, whatever the program length, and then wraps to entry 0.
- R5: After a loading session that writes N entries in a row from entry 0, only entry N-1 carries the end flag. A session that writes nothing leaves the marker where it was.
- R6: In run mode (`mode`=2'b11), a falling edge of `cnv_n` gives a one-cycle `conv_vld` with `conv_cfg` and `conv_eos` taken from the current entry, then advances the pointer. After the flagged entry, the pointer returns to 0.
- R7: Any edge on either `mode` bit resets the pointer to 0. Stored entries are kept across mode changes.
- R8: Write and read strobes are ignored in run mode, so `stat_oe` stays 0 and neither memory nor pointer changes. `cnv_n` is ignored outside run mode, so `conv_vld` stays 0.
- R9: Writing 16 entries wraps the pointer to 0, so a 17th write lands in entry 0. After such a session, entry 15 is the end of the program.
- R10: A write edge while `rd_n` is low stores nothing. A read edge while `wr_n` is low starts no readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Mode: 2'b10 access, 2'b11 run, others idle |
| wr_n | input | 1 | Write strobe, active low, acts on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| cnv_n | input | 1 | Conversion-start strobe, acts on its falling edge |
| cfg_in | input | 6 | Configuration word to store |
| stat_out | output | 7 | Readback word: entry in [6:1], end flag in [0] |
| stat_oe | output | 1 | Readback word valid (bus enable) |
| conv_vld | output | 1 | One-cycle pulse for each conversion start taken |
| conv_cfg | output | 6 | Configuration used for that conversion |
| conv_eos | output | 1 | That conversion used the last program entry |

## Verification
Each strobe or mode change is driven on a falling clock edge. The next rising edge sees it, and its result is due one cycle later. The bench therefore samples at the following falling edge, which is the only cycle in which a `conv_vld` pulse is visible. A readback word must appear one cycle after `rd_n` falls and must be gone one cycle after it rises. The bench checks both points, as well as `conv_vld` low again on the cycle after the pulse. Pointer effects that cannot be seen directly are checked through later readback or playback words.

// File: rtl/seqmem_pkg.sv
package seqmem_pkg;
  localparam int CFG_W  = 6;
  localparam int STAT_W = CFG_W + 1;

  typedef logic [CFG_W-1:0] cfg_t;

  typedef enum logic [1:0] {
    MODE_IDLE0  = 2'b00,
    MODE_IDLE1  = 2'b01,
    MODE_ACCESS = 2'b10,
    MODE_PLAY   = 2'b11
  } mode_e;

  // readback word: configuration above, end flag in the lowest bit
  function automatic logic [STAT_W-1:0] status_word(cfg_t c, logic last);
    return {c, last};
  endfunction
endpackage

// File: rtl/seqmem_edge_det.sv
module seqmem_edge_det #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= din;
  end

  assign rise = din & ~prev;
  assign fall = ~din & prev;
endmodule

// File: rtl/seqmem_store.sv
module seqmem_store
  import seqmem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cfg_t          wdata,
  input  logic [AW-1:0] raddr,
  output cfg_t          rdata
);
  cfg_t rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)                          rows[g] <= '0;
      else if (we && waddr == AW'(g))      rows[g] <= wdata;
    end
  end

  assign rdata = rows[raddr];
endmodule

// File: rtl/seqmem_ptr_ctl.sv
module seqmem_ptr_ctl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_edge,
  input  logic          wr_step,
  input  logic          rd_step,
  input  logic          play_step,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] end_idx
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic wrote;

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == TOP) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] play_next(logic [AW-1:0] p, logic [AW-1:0] e);
    return (p == e) ? '0 : wrap_inc(p);
  endfunction

  // first write of a session restarts the marker, later writes only raise it
  function automatic logic [AW-1:0] new_end(logic w, logic [AW-1:0] e, logic [AW-1:0] p);
    if (!w)    return p;
    if (p > e) return p;
    return e;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      end_idx <= TOP;
      wrote   <= 1'b0;
    end else if (mode_edge) begin
      ptr   <= '0;
      wrote <= 1'b0;
    end else if (wr_step) begin
      ptr     <= wrap_inc(ptr);
      end_idx <= new_end(wrote, end_idx, ptr);
      wrote   <= 1'b1;
    end else if (rd_step) begin
      ptr <= wrap_inc(ptr);
    end else if (play_step) begin
      ptr <= play_next(ptr, end_idx);
    end
  end

  assert_mode_edge_clears_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_edge |=> ptr == '0);

  assert_write_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step && !mode_edge && ptr != TOP |=> ptr == $past(ptr) + AW'(1));

  assert_full_write_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_step || rd_step) && !mode_edge && ptr == TOP |=> ptr == '0);

  assert_play_wraps_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    play_step && !mode_edge && ptr == end_idx |=> ptr == '0);

  assert_marker_covers_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step && !mode_edge |=> end_idx >= $past(ptr));
endmodule

// File: rtl/seq_program_mem.sv
module seq_program_mem
  import seqmem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              cnv_n,
  input  logic [CFG_W-1:0]  cfg_in,
  output logic [STAT_W-1:0] stat_out,
  output logic              stat_oe,
  output logic              conv_vld,
  output logic [CFG_W-1:0]  conv_cfg,
  output logic              conv_eos
);
  logic [2:0] stb_rise, stb_fall;
  logic [1:0] mode_rise, mode_fall;
  logic       mode_edge, in_access, in_play;
  logic       wr_step, rd_start, rd_step, play_step;
  logic [AW-1:0] ptr, end_idx;
  cfg_t       cur_cfg;
  logic       cur_last;

  seqmem_edge_det #(.W(3), .RST_VAL(3'b111)) i_stb_edges (
    .clk(clk), .rst_n(rst_n), .din({cnv_n, rd_n, wr_n}),
    .rise(stb_rise), .fall(stb_fall)
  );

  seqmem_edge_det #(.W(2), .RST_VAL(2'b00)) i_mode_edges (
    .clk(clk), .rst_n(rst_n), .din(mode),
    .rise(mode_rise), .fall(mode_fall)
  );

  assign mode_edge = |(mode_rise | mode_fall);
  assign in_access = (mode == MODE_ACCESS);
  assign in_play   = (mode == MODE_PLAY);

  assign wr_step   = stb_rise[0] && rd_n && in_access && !mode_edge;
  assign rd_start  = stb_fall[1] && wr_n && in_access && !mode_edge && !stat_oe;
  assign rd_step   = stb_rise[1] && stat_oe && in_access && !mode_edge && !wr_step;
  assign play_step = stb_fall[2] && in_play && !mode_edge;

  seqmem_ptr_ctl #(.DEPTH(DEPTH)) i_ptr (
    .clk(clk), .rst_n(rst_n), .mode_edge(mode_edge),
    .wr_step(wr_step), .rd_step(rd_step), .play_step(play_step),
    .ptr(ptr), .end_idx(end_idx)
  );

  seqmem_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .we(wr_step), .waddr(ptr), .wdata(cfg_in),
    .raddr(ptr), .rdata(cur_cfg)
  );

  assign cur_last = (ptr == end_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_oe  <= 1'b0;
      stat_out <= '0;
    end else if (mode_edge || rd_step || (stb_rise[1] && stat_oe)) begin
      stat_oe  <= 1'b0;
      stat_out <= '0;
    end else if (rd_start) begin
      stat_oe  <= 1'b1;
      stat_out <= status_word(cur_cfg, cur_last);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_vld <= 1'b0;
      conv_cfg <= '0;
      conv_eos <= 1'b0;
    end else begin
      conv_vld <= play_step;
      if (play_step) begin
        conv_cfg <= cur_cfg;
        conv_eos <= cur_last;
      end
    end
  end

  assert_oe_only_in_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oe && !mode_edge |-> in_access);

  assert_conv_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_vld |=> !conv_vld);

  assert_no_conv_outside_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_vld |-> $past(mode) == MODE_PLAY);

  assert_readback_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oe && !stb_rise[1] && !mode_edge |=> stat_oe && $stable(stat_out));

  assert_no_write_while_read_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !wr_step);
endmodule

// File: tb/test_seq_program_mem.sv
module test_seq_program_mem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wr_n = 1'b1, rd_n = 1'b1, cnv_n = 1'b1;
  logic [5:0] cfg_in = '0;
  logic [6:0] stat_out;
  logic       stat_oe, conv_vld, conv_eos;
  logic [5:0] conv_cfg;

  int total = 0;
  int bad = 0;
  logic [5:0] exp_mem [16];
  int exp_end = 15;

  always #10 clk = ~clk;

  seq_program_mem i_seq_program_mem (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_n(wr_n), .rd_n(rd_n), .cnv_n(cnv_n),
    .cfg_in(cfg_in), .stat_out(stat_out), .stat_oe(stat_oe),
    .conv_vld(conv_vld), .conv_cfg(conv_cfg), .conv_eos(conv_eos)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  task automatic enter_access();
    set_mode(2'b00);
    set_mode(2'b10);
  endtask

  task automatic wr_one(input logic [5:0] c);
    @(negedge clk); cfg_in = c; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_one(input int idx, input string req);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    chk(req, {31'd0, stat_oe}, 32'd1);
    chk(req, {25'd0, stat_out}, {25'd0, exp_mem[idx], idx == exp_end});
    rd_n = 1'b1;
    @(negedge clk);
    chk(req, {31'd0, stat_oe}, 32'd0);
  endtask

  task automatic cnv_one(input int idx, input string req);
    @(negedge clk); cnv_n = 1'b0;
    @(negedge clk);
    chk(req, {31'd0, conv_vld}, 32'd1);
    chk(req, {26'd0, conv_cfg}, {26'd0, exp_mem[idx]});
    chk(req, {31'd0, conv_eos}, {31'd0, idx == exp_end});
    cnv_n = 1'b1;
    @(negedge clk);
    chk(req, {31'd0, conv_vld}, 32'd0);
  endtask

  // R1 R4: reset state, readback of all 16 and wrap to entry 0
  task automatic t_reset();
    chk("R1 oe", {31'd0, stat_oe}, 32'd0);
    chk("R1 vld", {31'd0, conv_vld}, 32'd0);
    enter_access();
    for (int i = 0; i < 16; i++) rd_one(i, "R1 readback");
    rd_one(0, "R4 wrap");
  endtask

  // R2 R3 R5: five-entry program, marker on entry 4
  task automatic t_program5();
    logic [5:0] v [5] = '{6'h21, 6'h12, 6'h3F, 6'h05, 6'h2A};
    enter_access();
    for (int i = 0; i < 5; i++) begin
      wr_one(v[i]);
      exp_mem[i] = v[i];
    end
    exp_end = 4;
    enter_access();
    for (int i = 0; i < 6; i++) rd_one(i, "R2 R3 R5 readback");
  endtask

  // R6 R7 R8: playback, ignored strobes, mode-edge restart
  task automatic t_play();
    set_mode(2'b11);
    for (int i = 0; i < 7; i++) cnv_one(i % 5, "R6 play");
    @(negedge clk); cfg_in = 6'h3C; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    chk("R8 oe in run", {31'd0, stat_oe}, 32'd0);
    wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    cnv_one(2, "R8 ptr unmoved");
    set_mode(2'b10);
    set_mode(2'b11);
    cnv_one(0, "R7 restart");
    enter_access();
    @(negedge clk); cnv_n = 1'b0;
    @(negedge clk);
    chk("R8 cnv in access", {31'd0, conv_vld}, 32'd0);
    cnv_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) rd_one(i, "R7 R8 retained");
  endtask

  // R10: strobe interlock
  task automatic t_interlock();
    enter_access();
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    chk("R10 read with wr low", {31'd0, stat_oe}, 32'd0);
    rd_n = 1'b1;
    @(negedge clk); wr_n = 1'b1; cfg_in = 6'h07;
    @(negedge clk);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    chk("R10 read ok", {31'd0, stat_oe}, 32'd1);
    cfg_in = 6'h19; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    exp_mem[0] = 6'h07;
    exp_end = 0;
    enter_access();
    rd_one(0, "R10 entry0");
    rd_one(1, "R10 write ignored");
  endtask

  // R9 R5: full 16 writes plus one wrapping write, no-write session keeps marker
  task automatic t_full();
    enter_access();
    for (int i = 0; i < 16; i++) begin
      exp_mem[i] = 6'(i * 7 + 1);
      wr_one(exp_mem[i]);
    end
    wr_one(6'h15);
    exp_mem[0] = 6'h15;
    exp_end = 15;
    enter_access();
    for (int i = 0; i < 16; i++) rd_one(i, "R9 readback");
    enter_access();
    rd_one(0, "R5 kept");
    set_mode(2'b11);
    for (int i = 0; i < 17; i++) cnv_one(i % 16, "R9 play wrap");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program5();
    t_play();
    t_interlock();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule